// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts a single 128-bit block under a 128-bit cipher key, following the AES-128 forward cipher. It is iterative: one datapath holds the state, and a small controller steps it through an initial key whitening and ten rounds. All the arithmetic for a round is shared across the ten rounds. The round keys are produced on the fly by a separate key-schedule unit that advances in step with the state.

Every byte substitution passes through a registered lookup, which saves logic depth. Because of this, each round takes two controller cycles. In the first cycle, the state bytes and the rotated last key word go through the substitution and are captured. In the second cycle, the row shift, the column mix (skipped in the last round), the next round key and the key addition are applied and written back. The host sets the key and plaintext, pulses start, and waits for the one-cycle done pulse. It then reads the ciphertext, which stays put until the next accepted start.

Top module: `aes_iter_core`

## Requirements
- R1: While reset is held, and after it is released with no start, `doneOut` is 0 and `ctOut` is all zeros.
- R2: `ctOut` equals the AES-128 encryption of the `ptIn` value under the `keyIn` value, both sampled at the accepted start. Byte 0 of each 128-bit value is bits [127:120]. Bytes fill the state column by column. Key 000102…0f with plaintext 00112233…ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: If `startIn` is sampled high at rising edge N while the core is idle, `doneOut` is high in the cycle following edge N+20 and low before it.
- R4: `doneOut` is high for exactly one cycle per encryption.
- R5: After `doneOut`, `ctOut` holds its value, whatever `keyIn` and `ptIn` do, until the next accepted start.
- R6: A start pulse that arrives while an encryption is running is ignored. Neither the result nor the done timing of the running encryption changes.
- R7: Changes on `keyIn` and `ptIn` after the accepted start have no effect on the result.
- R8: A start sampled in the cycle where `doneOut` is high is accepted and begins a new encryption.
- R9: Every substitution cycle is followed by the round-completion cycle that consumes its registered result. The round counter stays within 1..10 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Begin an encryption (accepted when idle) |
| keyIn | input | 128 | Cipher key, byte 0 in bits [127:120] |
| ptIn | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| ctOut | output | 128 | Ciphertext, valid from the done pulse onward |
| doneOut | output | 1 | One-cycle pulse when the ciphertext is written |

## Verification
The embedded assertions check, on every cycle, properties of the sequencing. Done never lasts two cycles, and a substitution cycle is always followed by its consuming round cycle. The round counter stays in range and the round constant never becomes zero. The state and key registers stay frozen in cycles where no load or round-step strobe is raised. Whether the ciphertext is the correct AES result, the exact 20-cycle latency, and the handling of starts arriving while busy or back-to-back can only be shown by the bench. It runs the standard example vector, random vectors, and input changes during a run against its behavioural reference.

// File: rtl/aes_core_pkg.sv
package aes_core_pkg;

  localparam int NUM_ROUNDS = 10;
  localparam int BLOCK_W    = 128;
  localparam int WORD_W     = 32;
  localparam int NUM_BYTES  = BLOCK_W / 8;
  localparam int RND_W      = $clog2(NUM_ROUNDS + 1);

  typedef struct packed {
    logic load;   // whiten plaintext with cipher key, load key schedule
    logic sub;    // capture registered substitution results
    logic step;   // complete a round using captured substitution
    logic last;   // final round: bypass column mixing
  } ctlStrobes_t;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254, then the affine map
  function automatic logic [7:0] sboxByte(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] inv;
    pw  = a;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gfMul(pw, pw);
      inv = gfMul(inv, pw);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [WORD_W-1:0] mixCol(input logic [WORD_W-1:0] c);
    logic [7:0] a0, a1, a2, a3, t;
    a0 = c[31:24]; a1 = c[23:16]; a2 = c[15:8]; a3 = c[7:0];
    t  = a0 ^ a1 ^ a2 ^ a3;
    return {a0 ^ t ^ xtime(a0 ^ a1), a1 ^ t ^ xtime(a1 ^ a2),
            a2 ^ t ^ xtime(a2 ^ a3), a3 ^ t ^ xtime(a3 ^ a0)};
  endfunction

  function automatic logic [BLOCK_W-1:0] shiftRows(input logic [BLOCK_W-1:0] s);
    logic [BLOCK_W-1:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLOCK_W-1-8*(c*4+r) -: 8] = s[BLOCK_W-1-8*(((c+r)%4)*4+r) -: 8];
    return o;
  endfunction

  function automatic logic [BLOCK_W-1:0] mixColumns(input logic [BLOCK_W-1:0] s);
    logic [BLOCK_W-1:0] o;
    for (int c = 0; c < 4; c++)
      o[BLOCK_W-1-WORD_W*c -: WORD_W] = mixCol(s[BLOCK_W-1-WORD_W*c -: WORD_W]);
    return o;
  endfunction

endpackage

// File: rtl/aes_key_sched.sv
module aes_key_sched
  import aes_core_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic               subEn,
  input  logic               stepEn,
  input  logic [BLOCK_W-1:0] keyIn,
  output logic [BLOCK_W-1:0] nextKey
);

  logic [BLOCK_W-1:0] curKey;
  logic [7:0]         rcon;
  logic [WORD_W-1:0]  subWord;
  logic [WORD_W-1:0]  rotWord;
  logic [WORD_W-1:0]  mixTerm;
  logic [WORD_W-1:0]  w0, w1, w2, w3;

  assign rotWord = {curKey[23:0], curKey[31:24]};

  // registered substitution of the rotated last word
  for (genvar b = 0; b < 4; b++) begin : g_keySbox
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      subWord[8*b +: 8] <= 8'h00;
      else if (subEn) subWord[8*b +: 8] <= sboxByte(rotWord[8*b +: 8]);
    end
  end

  always_comb begin
    mixTerm = subWord ^ {rcon, 24'h000000};
    w0      = curKey[127:96] ^ mixTerm;
    w1      = curKey[95:64]  ^ w0;
    w2      = curKey[63:32]  ^ w1;
    w3      = curKey[31:0]   ^ w2;
    nextKey = {w0, w1, w2, w3};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curKey <= '0;
      rcon   <= 8'h01;
    end else if (loadEn) begin
      curKey <= keyIn;
      rcon   <= 8'h01;
    end else if (stepEn) begin
      curKey <= nextKey;
      rcon   <= xtime(rcon);
    end
  end

  // R7
  key_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loadEn || stepEn) |=> $stable(curKey));
  // R9
  rcon_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rcon != 8'h00);

endmodule

// File: rtl/aes_datapath.sv
module aes_datapath
  import aes_core_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic [BLOCK_W-1:0] ptIn,
  input  logic [BLOCK_W-1:0] keyIn,
  input  logic [BLOCK_W-1:0] roundKey,
  output logic [BLOCK_W-1:0] stateOut
);

  logic [BLOCK_W-1:0] stateReg;
  logic [BLOCK_W-1:0] subReg;
  logic [BLOCK_W-1:0] shifted;
  logic [BLOCK_W-1:0] roundOut;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_stateSbox
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        subReg[8*b +: 8] <= 8'h00;
      else if (ctl.sub) subReg[8*b +: 8] <= sboxByte(stateReg[8*b +: 8]);
    end
  end

  always_comb begin
    shifted  = shiftRows(subReg);
    roundOut = (ctl.last ? shifted : mixColumns(shifted)) ^ roundKey;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         stateReg <= '0;
    else if (ctl.load) stateReg <= ptIn ^ keyIn;
    else if (ctl.step) stateReg <= roundOut;
  end

  assign stateOut = stateReg;

  // R5
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load || ctl.step) |=> $stable(stateReg));

endmodule

// File: rtl/aes_ctrl.sv
module aes_ctrl
  import aes_core_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  output ctlStrobes_t ctl,
  output logic        doneOut
);

  typedef enum logic [1:0] {ST_IDLE, ST_SUB, ST_MIX} ctlState_t;

  ctlState_t       fsm;
  logic [RND_W-1:0] rnd;
  logic            lastRnd;

  assign lastRnd = (rnd == RND_W'(NUM_ROUNDS));

  always_comb begin
    ctl = '0;
    unique case (fsm)
      ST_IDLE: ctl.load = startIn;
      ST_SUB:  ctl.sub  = 1'b1;
      ST_MIX: begin
        ctl.step = 1'b1;
        ctl.last = lastRnd;
      end
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsm     <= ST_IDLE;
      rnd     <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      unique case (fsm)
        ST_IDLE: if (startIn) begin
          fsm <= ST_SUB;
          rnd <= RND_W'(1);
        end
        ST_SUB: fsm <= ST_MIX;
        ST_MIX: if (lastRnd) begin
          fsm     <= ST_IDLE;
          doneOut <= 1'b1;
        end else begin
          fsm <= ST_SUB;
          rnd <= rnd + RND_W'(1);
        end
        default: fsm <= ST_IDLE;
      endcase
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  // R9
  sub_then_mix_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsm == ST_SUB) |=> (fsm == ST_MIX));
  // R9
  rnd_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsm != ST_IDLE) |-> (rnd >= RND_W'(1) && rnd <= RND_W'(NUM_ROUNDS)));
  // R6
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsm == ST_MIX && !lastRnd) |=> (fsm == ST_SUB));

endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_core_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [BLOCK_W-1:0] keyIn,
  input  logic [BLOCK_W-1:0] ptIn,
  output logic [BLOCK_W-1:0] ctOut,
  output logic               doneOut
);

  ctlStrobes_t        ctl;
  logic [BLOCK_W-1:0] roundKey;

  aes_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .ctl     (ctl),
    .doneOut (doneOut)
  );

  aes_key_sched u_keySched (
    .clk     (clk),
    .rstN    (rstN),
    .loadEn  (ctl.load),
    .subEn   (ctl.sub),
    .stepEn  (ctl.step),
    .keyIn   (keyIn),
    .nextKey (roundKey)
  );

  aes_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .ptIn     (ptIn),
    .keyIn    (keyIn),
    .roundKey (roundKey),
    .stateOut (ctOut)
  );

endmodule

// File: tb/aes_iter_core_bench.sv
module aes_iter_core_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [127:0] keyIn = '0;
  logic [127:0] ptIn = '0;
  logic [127:0] ctOut;
  logic         doneOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  aes_iter_core u_aes_iter_core (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .keyIn(keyIn), .ptIn(ptIn), .ctOut(ctOut), .doneOut(doneOut)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] sbT [256];

  function automatic logic [7:0] dbl(input logic [7:0] b);
    return (b << 1) ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  task automatic buildSbox();
    logic [7:0] p = 8'h01;
    logic [7:0] q = 8'h01;
    do begin
      p = p ^ dbl(p);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sbT[p] = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sbT[0] = 8'h63;
  endtask

  function automatic logic [127:0] refEncrypt(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] w [176];
    logic [7:0] tmp [4];
    logic [7:0] rc;
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      w[i] = k[127-8*i -: 8];
      s[i] = p[127-8*i -: 8];
    end
    for (int i = 4; i < 44; i++) begin
      for (int j = 0; j < 4; j++) tmp[j] = w[(i-1)*4+j];
      if (i % 4 == 0) begin
        logic [7:0] f;
        f = tmp[0];
        tmp[0] = sbT[tmp[1]] ^ rc;
        tmp[1] = sbT[tmp[2]];
        tmp[2] = sbT[tmp[3]];
        tmp[3] = sbT[f];
        rc = dbl(rc);
      end
      for (int j = 0; j < 4; j++) w[i*4+j] = w[(i-4)*4+j] ^ tmp[j];
    end
    for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[i];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sbT[s[i]];
      for (int c = 0; c < 4; c++)
        for (int rr = 0; rr < 4; rr++) t[c*4+rr] = s[((c+rr)%4)*4+rr];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          s[c*4+0] = dbl(t[c*4]) ^ dbl(t[c*4+1]) ^ t[c*4+1] ^ t[c*4+2] ^ t[c*4+3];
          s[c*4+1] = t[c*4] ^ dbl(t[c*4+1]) ^ dbl(t[c*4+2]) ^ t[c*4+2] ^ t[c*4+3];
          s[c*4+2] = t[c*4] ^ t[c*4+1] ^ dbl(t[c*4+2]) ^ dbl(t[c*4+3]) ^ t[c*4+3];
          s[c*4+3] = dbl(t[c*4]) ^ t[c*4] ^ t[c*4+1] ^ t[c*4+2] ^ dbl(t[c*4+3]);
        end else begin
          for (int rr = 0; rr < 4; rr++) s[c*4+rr] = t[c*4+rr];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[r*16+i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  // ---------------- cycle model ----------------
  int           busyCnt = 0;
  logic         expDone = 1'b0;
  logic [127:0] expCt = '0;
  logic [127:0] pendCt = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      busyCnt = 0; expDone = 1'b0; expCt = '0;
    end else begin
      expDone = 1'b0;
      if (busyCnt > 0) begin
        busyCnt = busyCnt - 1;
        if (busyCnt == 0) begin
          expDone = 1'b1;
          expCt = pendCt;
        end
      end else if (startIn) begin
        busyCnt = 20;
        pendCt = refEncrypt(keyIn, ptIn);
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      total++;
      if (doneOut !== expDone) begin
        bad++;
        $display("FAIL R3 R4 done (%s) actual=%b expected=%b", curReq, doneOut, expDone);
      end
      if (busyCnt == 0) begin
        total++;
        if (ctOut !== expCt) begin
          bad++;
          $display("FAIL R2 R5 ciphertext (%s) actual=%h expected=%h", curReq, ctOut, expCt);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      total++; bad++;
      $display("FAIL watchdog (%s) actual=%0d expected=below 50000", curReq, cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [127:0] k, input logic [127:0] p);
    @(negedge clk);
    keyIn = k; ptIn = p; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (doneOut !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    buildSbox();
    check("R2 reference self-test",
          refEncrypt(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff),
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    repeat (3) @(negedge clk);
    check("R1 reset ct", ctOut, '0);
    check("R1 reset done", {127'b0, doneOut}, '0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle after reset", ctOut, '0);

    curReq = "R2";
    pulseStart(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff);
    waitDone();
    check("R2 standard vector", ctOut, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    for (int v = 0; v < 6; v++) begin
      pulseStart({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
      waitDone();
    end

    curReq = "R6";
    pulseStart(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734);
    repeat (4) @(negedge clk);
    keyIn = '1; ptIn = '0; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    waitDone();
    check("R6 busy start ignored", ctOut, 128'h3925841d02dc09fbdc118597196a0b32);

    curReq = "R7";
    pulseStart(128'h0f0e0d0c0b0a09080706050403020100, 128'hffeeddccbbaa99887766554433221100);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      keyIn = {4{$urandom}}; ptIn = {4{$urandom}};
    end
    waitDone();

    curReq = "R8";
    @(negedge clk);
    keyIn = 128'h11; ptIn = 128'h22; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    waitDone();
    keyIn = 128'h33; ptIn = 128'h44; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    waitDone();

    curReq = "R5";
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      keyIn = {4{$urandom}}; ptIn = {4{$urandom}};
    end
    check("R5 ct held while idle", ctOut, refEncrypt(128'h33, 128'h44));

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule